// File: doc/BRIEF.md
# PRG and CHR Bank Translator

This block turns two logical addresses into physical memory addresses for a bank-switched cartridge. The CPU side presents a 15-bit offset into its 32 KB program window. Bit 14 picks one of two 16 KB windows. The video side presents a 13-bit pattern address. Bit 12 picks one of two 4 KB halves. Mode bits and bank numbers come from a separate mapper register file and arrive as plain inputs.

The program side works in one of two modes. In the paired mode one 32 KB bank is selected. In the single mode one window follows the bank register and the other is pinned: to the first bank, or to the last bank of the 4-bit bank space. The pattern side works in one of two modes. In the paired mode one 8 KB bank is selected and the low bank bit is ignored. In the split mode each 4 KB half has its own register.

Bank numbers are cut to the fitted memory size by parameter masks. Each mask must be a power of two minus one. Both translated addresses are registered, so each output follows its inputs by one clock.

Top module: `bank_xlat`

## Requirements
- R1: While `rst` is high at a clock edge, both physical outputs become zero.
- R2: With `prg_mode`=0 (32 KB), the program bank is `prg_bank` with bit 0 replaced by `cpu_addr[14]`.
- R3: With `prg_mode`=1 and `prg_fix_high`=0, `cpu_addr[14]`=0 selects bank 0 and `cpu_addr[14]`=1 selects `prg_bank`.
- R4: With `prg_mode`=1 and `prg_fix_high`=1, `cpu_addr[14]`=0 selects `prg_bank` and `cpu_addr[14]`=1 selects bank 15 (all ones).
- R5: With `chr_split`=0 (8 KB), the pattern bank is `chr_sel_a` with bit 0 replaced by `ppu_addr[12]`; `chr_sel_b` has no effect.
- R6: With `chr_split`=1, `ppu_addr[12]`=0 selects `chr_sel_a` and `ppu_addr[12]`=1 selects `chr_sel_b`.
- R7: `prg_phys` = ((selected bank AND `PRG_MASK`) << 14) | `cpu_addr[13:0]`.
- R8: `chr_phys` = ((selected bank AND `CHR_MASK`) << 12) | `ppu_addr[11:0]`.
- R9: Each output reflects the inputs sampled at the previous rising clock edge and holds between edges.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cpu_addr | input | 15 | CPU offset within the 32 KB program window |
| ppu_addr | input | 13 | Video pattern address |
| prg_mode | input | 1 | 0: 32 KB paired, 1: 16 KB with one pinned window |
| prg_fix_high | input | 1 | In 16 KB mode, 0 pins the lower window, 1 pins the upper window |
| chr_split | input | 1 | 0: 8 KB paired, 1: two independent 4 KB halves |
| prg_bank | input | 4 | Program bank register |
| chr_sel_a | input | 5 | Pattern bank for the lower half (and for paired mode) |
| chr_sel_b | input | 5 | Pattern bank for the upper half in split mode |
| prg_phys | output | 18 | Physical program byte address |
| chr_phys | output | 17 | Physical pattern byte address |

## Verification
The program and pattern translations are independent, and both are updated on the same clock edge. The bench changes both address streams and all mode bits in the same cycle. It first walks all 32 combinations of program mode, pinned side, pattern mode and both window bits, then runs a long random phase. A behavioural model predicts both outputs for every cycle, and the bench compares each output separately, so a fault on one path cannot hide behind the other. Just before each edge, the bench also checks that both outputs still hold their previous values.

// File: rtl/bank_xlat_pkg.sv
package bank_xlat_pkg;
  localparam int PRG_OFS_W = 14;
  localparam int CHR_OFS_W = 12;

  typedef enum logic {PRG_PAIRED = 1'b0, PRG_SINGLE = 1'b1} prg_mode_e;
  typedef enum logic {FIX_LOW = 1'b0, FIX_HIGH = 1'b1} prg_fix_e;
  typedef enum logic {CHR_PAIRED = 1'b0, CHR_SPLIT = 1'b1} chr_mode_e;
endpackage

// File: rtl/prg_window_sel.sv
module prg_window_sel
  import bank_xlat_pkg::*;
#(
  parameter int BW = 4
) (
  input  prg_mode_e         mode,
  input  prg_fix_e          fix,
  input  logic [BW-1:0]     bank,
  input  logic              hi_win,
  output logic [BW-1:0]     sel
);
  always_comb begin
    sel = bank;
    unique case (mode)
      PRG_PAIRED: sel = {bank[BW-1:1], hi_win};
      PRG_SINGLE: begin
        if (fix == FIX_LOW) sel = hi_win ? bank : '0;
        else                sel = hi_win ? '1 : bank;
      end
      default: sel = bank;
    endcase
  end
endmodule

// File: rtl/chr_half_sel.sv
module chr_half_sel
  import bank_xlat_pkg::*;
#(
  parameter int BW = 5
) (
  input  chr_mode_e         mode,
  input  logic [BW-1:0]     bank_a,
  input  logic [BW-1:0]     bank_b,
  input  logic              hi_half,
  output logic [BW-1:0]     sel
);
  always_comb begin
    sel = bank_a;
    unique case (mode)
      CHR_PAIRED: sel = {bank_a[BW-1:1], hi_half};
      CHR_SPLIT:  sel = hi_half ? bank_b : bank_a;
      default:    sel = bank_a;
    endcase
  end
endmodule

// File: rtl/phys_addr_reg.sv
module phys_addr_reg #(
  parameter int BW    = 4,
  parameter int OFS_W = 14,
  parameter int MASK  = 7
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic [BW-1:0]         bank,
  input  logic [OFS_W-1:0]      ofs,
  output logic [BW+OFS_W-1:0]   phys
);
  localparam logic [BW-1:0] MASK_V = MASK[BW-1:0];

  always_ff @(posedge clk) begin
    if (rst) phys <= '0;
    else     phys <= {bank & MASK_V, ofs};
  end
endmodule

// File: rtl/bank_xlat.sv
module bank_xlat
  import bank_xlat_pkg::*;
#(
  parameter int PRG_BANK_W = 4,
  parameter int CHR_BANK_W = 5,
  parameter int PRG_MASK   = 7,
  parameter int CHR_MASK   = 15,
  localparam int PRG_PA_W  = PRG_BANK_W + PRG_OFS_W,
  localparam int CHR_PA_W  = CHR_BANK_W + CHR_OFS_W
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic [PRG_OFS_W:0]     cpu_addr,
  input  logic [CHR_OFS_W:0]     ppu_addr,
  input  logic                   prg_mode,
  input  logic                   prg_fix_high,
  input  logic                   chr_split,
  input  logic [PRG_BANK_W-1:0]  prg_bank,
  input  logic [CHR_BANK_W-1:0]  chr_sel_a,
  input  logic [CHR_BANK_W-1:0]  chr_sel_b,
  output logic [PRG_PA_W-1:0]    prg_phys,
  output logic [CHR_PA_W-1:0]    chr_phys
);
  localparam logic [PRG_BANK_W-1:0] PRG_MASK_V = PRG_MASK[PRG_BANK_W-1:0];
  localparam logic [CHR_BANK_W-1:0] CHR_MASK_V = CHR_MASK[CHR_BANK_W-1:0];

  logic [PRG_BANK_W-1:0] prg_sel;
  logic [CHR_BANK_W-1:0] chr_sel;

  prg_window_sel #(.BW(PRG_BANK_W)) u_prg_sel (
    .mode   (prg_mode_e'(prg_mode)),
    .fix    (prg_fix_e'(prg_fix_high)),
    .bank   (prg_bank),
    .hi_win (cpu_addr[PRG_OFS_W]),
    .sel    (prg_sel)
  );

  chr_half_sel #(.BW(CHR_BANK_W)) u_chr_sel (
    .mode    (chr_mode_e'(chr_split)),
    .bank_a  (chr_sel_a),
    .bank_b  (chr_sel_b),
    .hi_half (ppu_addr[CHR_OFS_W]),
    .sel     (chr_sel)
  );

  phys_addr_reg #(.BW(PRG_BANK_W), .OFS_W(PRG_OFS_W), .MASK(PRG_MASK)) u_prg_reg (
    .clk  (clk),
    .rst  (rst),
    .bank (prg_sel),
    .ofs  (cpu_addr[PRG_OFS_W-1:0]),
    .phys (prg_phys)
  );

  phys_addr_reg #(.BW(CHR_BANK_W), .OFS_W(CHR_OFS_W), .MASK(CHR_MASK)) u_chr_reg (
    .clk  (clk),
    .rst  (rst),
    .bank (chr_sel),
    .ofs  (ppu_addr[CHR_OFS_W-1:0]),
    .phys (chr_phys)
  );

  // R9
  prg_offset_chk: assert property (@(posedge clk) disable iff (rst)
    !$past(rst) |-> prg_phys[PRG_OFS_W-1:0] == $past(cpu_addr[PRG_OFS_W-1:0]));

  // R4
  prg_fixed_top_chk: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $past(prg_mode) && $past(prg_fix_high) && $past(cpu_addr[PRG_OFS_W]))
    |-> prg_phys[PRG_PA_W-1:PRG_OFS_W] == PRG_MASK_V);

  // R3
  prg_fixed_low_chk: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $past(prg_mode) && !$past(prg_fix_high) && !$past(cpu_addr[PRG_OFS_W]))
    |-> prg_phys[PRG_PA_W-1:PRG_OFS_W] == '0);

  // R7
  prg_mask_chk: assert property (@(posedge clk) disable iff (rst)
    (prg_phys[PRG_PA_W-1:PRG_OFS_W] & ~PRG_MASK_V) == '0);

  // R8
  chr_mask_chk: assert property (@(posedge clk) disable iff (rst)
    (chr_phys[CHR_PA_W-1:CHR_OFS_W] & ~CHR_MASK_V) == '0);

  // R5
  chr_pair_chk: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && !$past(chr_split) && CHR_MASK_V[0])
    |-> chr_phys[CHR_OFS_W] == $past(ppu_addr[CHR_OFS_W]));
endmodule

// File: tb/sim_bank_xlat.sv
`timescale 1ns/1ps
module sim_bank_xlat;
  localparam int PRG_MASK = 7;
  localparam int CHR_MASK = 15;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [14:0] cpu_addr = '0;
  logic [12:0] ppu_addr = '0;
  logic        prg_mode = 1'b0, prg_fix_high = 1'b0, chr_split = 1'b0;
  logic [3:0]  prg_bank = '0;
  logic [4:0]  chr_sel_a = '0, chr_sel_b = '0;
  logic [17:0] prg_phys;
  logic [16:0] chr_phys;

  int checks = 0, fails = 0;
  int exp_prg = 0, exp_chr = 0;
  string prg_tag = "R1", chr_tag = "R1";
  bit mask_phase = 0;
  bit done = 0;

  bank_xlat #(.PRG_MASK(PRG_MASK), .CHR_MASK(CHR_MASK)) u0 (
    .clk, .rst, .cpu_addr, .ppu_addr, .prg_mode, .prg_fix_high, .chr_split,
    .prg_bank, .chr_sel_a, .chr_sel_b, .prg_phys, .chr_phys
  );

  always #4 clk = ~clk;

  task automatic chk(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  // behavioural reference for the values the design will show after the next edge
  task automatic model();
    int b, a14, a12;
    a14 = int'(cpu_addr[14]);
    a12 = int'(ppu_addr[12]);
    if (!prg_mode) begin b = (int'(prg_bank) / 2) * 2 + a14; prg_tag = "R2"; end
    else if (!prg_fix_high) begin b = a14 ? int'(prg_bank) : 0; prg_tag = "R3"; end
    else begin b = a14 ? 15 : int'(prg_bank); prg_tag = "R4"; end
    b = b & PRG_MASK;
    exp_prg = b * 16384 + (int'(cpu_addr) % 16384);
    if (!chr_split) begin b = (int'(chr_sel_a) / 2) * 2 + a12; chr_tag = "R5"; end
    else begin b = a12 ? int'(chr_sel_b) : int'(chr_sel_a); chr_tag = "R6"; end
    b = b & CHR_MASK;
    exp_chr = b * 4096 + (int'(ppu_addr) % 4096);
    if (mask_phase) begin prg_tag = "R7"; chr_tag = "R8"; end
  endtask

  // called at a falling edge: checks the previous cycle, then drives the next one
  task automatic step(logic pm, logic fx, logic cs, logic [14:0] ca, logic [12:0] pa,
                      logic [3:0] pb, logic [4:0] ba, logic [4:0] bb);
    chk(prg_tag, int'(prg_phys), exp_prg);
    chk(chr_tag, int'(chr_phys), exp_chr);
    prg_mode = pm; prg_fix_high = fx; chr_split = cs;
    cpu_addr = ca; ppu_addr = pa; prg_bank = pb; chr_sel_a = ba; chr_sel_b = bb;
    #1;
    // R9: new inputs must not reach the outputs before the edge
    chk("R9", int'(prg_phys), exp_prg);
    chk("R9", int'(chr_phys), exp_chr);
    model();
    @(negedge clk);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk("R1", int'(prg_phys), 0);
    chk("R1", int'(chr_phys), 0);
    rst = 1'b0;
    model();
    @(negedge clk);
    // every mode / pinned side / window combination
    for (int k = 0; k < 32; k++) begin
      step(k[0], k[1], k[2], {k[3], 14'($urandom)}, {k[4], 12'($urandom)},
           4'($urandom), 5'($urandom), 5'($urandom));
    end
    // R5: second pattern register changes while paired, output must not
    step(1'b0, 1'b0, 1'b0, 15'h1234, 13'h1abc, 4'h6, 5'h0a, 5'h00);
    step(1'b0, 1'b0, 1'b0, 15'h1234, 13'h1abc, 4'h6, 5'h0a, 5'h1f);
    // R7 / R8: bank numbers beyond the fitted size
    mask_phase = 1;
    for (int k = 0; k < 16; k++) begin
      step(k[0], k[1], k[2], {k[3], 14'h3fff}, {k[3], 12'hfff}, 4'hf, 5'h1f, 5'h13);
    end
    mask_phase = 0;
    for (int k = 0; k < 3000; k++) begin
      step(1'($urandom), 1'($urandom), 1'($urandom), 15'($urandom), 13'($urandom),
           4'($urandom), 5'($urandom), 5'($urandom));
    end
    chk(prg_tag, int'(prg_phys), exp_prg);
    chk(chr_tag, int'(chr_phys), exp_chr);
    // R1: reset applied again clears both outputs
    rst = 1'b1;
    @(negedge clk);
    chk("R1", int'(prg_phys), 0);
    chk("R1", int'(chr_phys), 0);
    done = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    #(8 * 200000);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end
endmodule